// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This block holds a 42-bit signed accumulator, kept as a 10-bit upper part and a 32-bit lower part, and serves six command codes on one command channel. Commands zero the accumulator, write either part from a 32-bit word, read either part back as a 32-bit word, or run one multiply-accumulate step. The host owns the pointer registers. An accumulate command carries two byte addresses. The unit reads one signed 16-bit halfword at each address through a single-port memory read interface, adds the signed product of the two halfwords to the accumulator, and returns both pointers after they have been advanced. The unit keeps four condition flags (zero, negative, overflow, carry) and shows them on plain output pins.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is accepted on a rising edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low the unit ignores `cmd_valid`, and the producer holds its command until the unit is ready again. The result side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the host must capture `rsp_data` and the two pointer outputs in that cycle.

Top module: `mac_acc_unit`

## Requirements
- R1: Command code 0 sets all 42 accumulator bits to zero and leaves all four flags unchanged. It produces a one-cycle `rsp_valid` pulse.
- R2: Command code 5 multiplies two signed 16-bit halfwords and adds the full signed product to the accumulator, modulo 2^42. There is no saturation.
- R3: Command code 1 writes bits 9:0 of `cmd_wdata` to the upper part. Command code 2 writes all 32 bits to the lower part. Both codes clear the overflow and carry flags.
- R4: Command code 3 returns the upper part sign-extended from its bit 9 to 32 bits. Command code 4 returns the lower part. Both answers appear on `rsp_data` with `rsp_valid`.
- R5: On code 3 or code 4, `flag_zero` is set only when all 42 accumulator bits are zero. It does not depend on which part is read.
- R6: On code 3 or code 4, `flag_neg` takes accumulator bit 41 and `flag_ovf` is cleared.
- R7: The first operand is read from `cmd_ptr_a` and that pointer then advances by 2. When `cmd_same_ptr` is 0, the second operand is read from `cmd_ptr_b` and that pointer then advances by 2. When `cmd_same_ptr` is 1, the second operand is read from `cmd_ptr_a`+2, and both returned pointers equal `cmd_ptr_a`+4.
- R8: A carry out of bit 31 propagates into the upper part. Eight accumulations of 0x7fff times 0x7fff, starting from zero, give an upper part of 1 and a lower part of 0xfff80008.
- R9: An accepted code 5 drives `mem_req` with the first address in the cycle after acceptance. It drives the second address in the cycle after that. It pulses `rsp_valid` three edges after acceptance. During this time `cmd_ready` stays low and any command offered is ignored. Codes 0 to 4 answer one edge after acceptance.
- R10: Synchronous active-high reset clears the accumulator and the flags, and returns the unit to idle.
- R11: Codes 6 and 7 produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle; an offered command is taken on this edge |
| cmd_op | input | 3 | Command code: 0 clear, 1 load upper, 2 load lower, 3 read upper, 4 read lower, 5 accumulate |
| cmd_wdata | input | 32 | Load value |
| cmd_ptr_a | input | 32 | First operand byte address |
| cmd_ptr_b | input | 32 | Second operand byte address |
| cmd_same_ptr | input | 1 | Both operands use `cmd_ptr_a` |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 16 | Halfword read data, valid one cycle after the request |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 32 | Read-back word; zero for other commands |
| rsp_ptr_a | output | 32 | Advanced first pointer after code 5; zero otherwise |
| rsp_ptr_b | output | 32 | Advanced second pointer after code 5; zero otherwise |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_carry | output | 1 | Carry flag |

## Verification
Counting from the edge that accepts a command, the answer to codes 0 to 4 and the updated flags are due one edge later. An accumulate puts its first address on the bus one edge after acceptance and its answer three edges after acceptance. The driver offers each command on a falling edge. It then waits exactly those edge counts before it checks the flags, `mem_req` or `cmd_ready`. A monitor compares `rsp_data` and the pointers on the falling edge of every `rsp_valid` cycle against a queue of expected answers. Any answer that arrives with an empty queue, and any answer still in the queue at the end, counts as a miscompare.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_CLR = 3'd0,
    OP_LDH = 3'd1,
    OP_LDL = 3'd2,
    OP_STH = 3'd3,
    OP_STL = 3'd4,
    OP_ACC = 3'd5
  } mac_op_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_OPA,
    FS_OPB,
    FS_MUL
  } fetch_st_e;
endpackage

// File: rtl/mac_fetch.sv
module mac_fetch
  import mac_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   ptr_a_in,
  input  logic [AW-1:0]   ptr_b_in,
  input  logic            same_in,
  input  logic [OP_W-1:0] mem_rdata,
  output logic            idle,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic            mul_fire,
  output logic [OP_W-1:0] op_a,
  output logic [OP_W-1:0] op_b,
  output logic [AW-1:0]   ptr_a_out,
  output logic [AW-1:0]   ptr_b_out
);
  localparam logic [AW-1:0] STEP = AW'(OP_W / 8);

  fetch_st_e       state;
  logic [AW-1:0]   pa, pb;
  logic            same_q;
  logic [OP_W-1:0] opa_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      pa     <= '0;
      pb     <= '0;
      same_q <= 1'b0;
      opa_q  <= '0;
    end else begin
      unique case (state)
        FS_IDLE: if (start) begin
          pa     <= ptr_a_in;
          pb     <= ptr_b_in;
          same_q <= same_in;
          state  <= FS_OPA;
        end
        FS_OPA: begin
          pa    <= pa + STEP;
          state <= FS_OPB;
        end
        FS_OPB: begin
          opa_q <= mem_rdata;
          if (same_q) pa <= pa + STEP;
          else        pb <= pb + STEP;
          state <= FS_MUL;
        end
        FS_MUL: state <= FS_IDLE;
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign idle      = (state == FS_IDLE);
  assign mem_req   = (state == FS_OPA) || (state == FS_OPB);
  assign mem_addr  = (state == FS_OPB && !same_q) ? pb : pa;
  assign mul_fire  = (state == FS_MUL);
  assign op_a      = opa_q;
  assign op_b      = mem_rdata;
  assign ptr_a_out = pa;
  assign ptr_b_out = same_q ? pa : pb;

  // R9
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && idle) |=> (mem_req && mem_addr == $past(ptr_a_in)));

  // R7
  same_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == FS_OPB && same_q) |-> (mem_addr == $past(mem_addr) + STEP));
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int HI_W = 10,
  parameter int LO_W = 32,
  parameter int OP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 ld_hi,
  input  logic                 ld_lo,
  input  logic [LO_W-1:0]      wdata,
  input  logic                 mul_fire,
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  output logic [HI_W+LO_W-1:0] acc
);
  localparam int ACC_W  = HI_W + LO_W;
  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_ext;

  assign prod     = $signed(op_a) * $signed(op_b);
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (ld_hi) begin
      acc[ACC_W-1:LO_W] <= wdata[HI_W-1:0];
    end else if (ld_lo) begin
      acc[LO_W-1:0] <= wdata;
    end else if (mul_fire) begin
      acc <= acc + prod_ext;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));

  // R3
  load_hi_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !clr) |=> (acc[ACC_W-1:LO_W] == $past(wdata[HI_W-1:0])
                         && acc[LO_W-1:0] == $past(acc[LO_W-1:0])));

  // R9
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ld_hi && !ld_lo && !mul_fire) |=> $stable(acc));
endmodule

// File: rtl/mac_readback.sv
module mac_readback #(
  parameter int HI_W = 10,
  parameter int LO_W = 32
) (
  input  logic [HI_W+LO_W-1:0] acc,
  input  logic                 sel_hi,
  output logic [LO_W-1:0]      word,
  output logic                 is_zero,
  output logic                 is_neg
);
  localparam int ACC_W = HI_W + LO_W;

  logic [LO_W-1:0] hi_ext;

  assign hi_ext  = {{(LO_W-HI_W){acc[ACC_W-1]}}, acc[ACC_W-1:LO_W]};
  assign word    = sel_hi ? hi_ext : acc[LO_W-1:0];
  assign is_zero = (acc == '0);
  assign is_neg  = acc[ACC_W-1];
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int AW   = 32,
  parameter int HI_W = 10,
  parameter int LO_W = 32,
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [LO_W-1:0] cmd_wdata,
  input  logic [AW-1:0]   cmd_ptr_a,
  input  logic [AW-1:0]   cmd_ptr_b,
  input  logic            cmd_same_ptr,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic [OP_W-1:0] mem_rdata,
  output logic            rsp_valid,
  output logic [LO_W-1:0] rsp_data,
  output logic [AW-1:0]   rsp_ptr_a,
  output logic [AW-1:0]   rsp_ptr_b,
  output logic            flag_zero,
  output logic            flag_neg,
  output logic            flag_ovf,
  output logic            flag_carry
);
  localparam int ACC_W = HI_W + LO_W;

  logic             accept;
  logic             do_clr, do_ldh, do_ldl, do_sth, do_stl, do_acc;
  logic             is_load, is_store;
  logic             idle, mul_fire;
  logic [OP_W-1:0]  op_a, op_b;
  logic [AW-1:0]    fp_a, fp_b;
  logic [ACC_W-1:0] acc;
  logic [LO_W-1:0]  rb_word;
  logic             rb_zero, rb_neg;

  assign cmd_ready = idle;
  assign accept    = cmd_valid && cmd_ready;
  assign do_clr    = accept && (cmd_op == OP_CLR);
  assign do_ldh    = accept && (cmd_op == OP_LDH);
  assign do_ldl    = accept && (cmd_op == OP_LDL);
  assign do_sth    = accept && (cmd_op == OP_STH);
  assign do_stl    = accept && (cmd_op == OP_STL);
  assign do_acc    = accept && (cmd_op == OP_ACC);
  assign is_load   = do_ldh || do_ldl;
  assign is_store  = do_sth || do_stl;

  mac_fetch #(.AW(AW), .OP_W(OP_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (do_acc),
    .ptr_a_in  (cmd_ptr_a),
    .ptr_b_in  (cmd_ptr_b),
    .same_in   (cmd_same_ptr),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mul_fire  (mul_fire),
    .op_a      (op_a),
    .op_b      (op_b),
    .ptr_a_out (fp_a),
    .ptr_b_out (fp_b)
  );

  mac_acc #(.HI_W(HI_W), .LO_W(LO_W), .OP_W(OP_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (do_clr),
    .ld_hi    (do_ldh),
    .ld_lo    (do_ldl),
    .wdata    (cmd_wdata),
    .mul_fire (mul_fire),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc      (acc)
  );

  mac_readback #(.HI_W(HI_W), .LO_W(LO_W)) u_rb (
    .acc     (acc),
    .sel_hi  (do_sth),
    .word    (rb_word),
    .is_zero (rb_zero),
    .is_neg  (rb_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_ptr_a  <= '0;
      rsp_ptr_b  <= '0;
      flag_zero  <= 1'b0;
      flag_neg   <= 1'b0;
      flag_ovf   <= 1'b0;
      flag_carry <= 1'b0;
    end else begin
      rsp_valid <= do_clr || is_load || is_store || mul_fire;
      rsp_data  <= is_store ? rb_word : '0;
      rsp_ptr_a <= mul_fire ? fp_a : '0;
      rsp_ptr_b <= mul_fire ? fp_b : '0;
      if (is_store) begin
        flag_zero <= rb_zero;
        flag_neg  <= rb_neg;
        flag_ovf  <= 1'b0;
      end
      if (is_load) begin
        flag_ovf   <= 1'b0;
        flag_carry <= 1'b0;
      end
    end
  end

  // R1
  clear_flags_kept_chk: assert property (@(posedge clk) disable iff (rst)
    do_clr |=> ($stable(flag_zero) && $stable(flag_neg)
                && $stable(flag_ovf) && $stable(flag_carry)));

  // R3
  load_flags_chk: assert property (@(posedge clk) disable iff (rst)
    is_load |=> (!flag_ovf && !flag_carry && rsp_valid));

  // R6
  store_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    is_store |=> (!flag_ovf && rsp_valid));

  // R11
  bad_op_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op > 3'd5) |=> (!rsp_valid && $stable(acc)));
endmodule

// File: tb/tb_mac_acc_unit.sv
module tb_mac_acc_unit;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_ptr_a, cmd_ptr_b;
  logic        cmd_same_ptr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_data, rsp_ptr_a, rsp_ptr_b;
  logic        flag_zero, flag_neg, flag_ovf, flag_carry;

  always #4 clk = ~clk;

  mac_acc_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ptr_a(cmd_ptr_a),
    .cmd_ptr_b(cmd_ptr_b), .cmd_same_ptr(cmd_same_ptr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ptr_a(rsp_ptr_a), .rsp_ptr_b(rsp_ptr_b),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf),
    .flag_carry(flag_carry)
  );

  logic [15:0] mem [0:31];
  always @(posedge clk) mem_rdata <= mem[mem_addr[5:1]];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [41:0] m_acc;

  logic [31:0] q_data[$];
  logic [31:0] q_pa[$];
  logic [31:0] q_pb[$];
  string       q_tag[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [31:0] d,
                      input logic [31:0] pa, input logic [31:0] pb);
    q_data.push_back(d); q_pa.push_back(pa); q_pb.push_back(pb); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11: actual unexpected response %h expected none", rsp_data);
      end else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " data"}, rsp_data, q_data.pop_front());
        chk({t, " ptr_a"}, rsp_ptr_a, q_pa.pop_front());
        chk({t, " ptr_b"}, rsp_ptr_b, q_pb.pop_front());
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [31:0] d,
                       input logic [31:0] pa, input logic [31:0] pb, input logic same);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    cmd_ptr_a = pa; cmd_ptr_b = pb; cmd_same_ptr = same;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [31:0] hi_word();
    return {{22{m_acc[41]}}, m_acc[41:32]};
  endfunction

  task automatic clr_cmd(input string tag);
    push(tag, 32'h0, 32'h0, 32'h0);
    m_acc = '0;
    issue(3'd0, 32'h0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic load(input bit hi, input logic [31:0] d);
    push("R3 load", 32'h0, 32'h0, 32'h0);
    if (hi) m_acc[41:32] = d[9:0]; else m_acc[31:0] = d;
    issue(hi ? 3'd1 : 3'd2, d, 32'h0, 32'h0, 1'b0);
    chk("R3 load ovf", {31'h0, flag_ovf}, 32'h0);
    chk("R3 load carry", {31'h0, flag_carry}, 32'h0);
  endtask

  task automatic store(input bit hi, input string tag);
    push(tag, hi ? hi_word() : m_acc[31:0], 32'h0, 32'h0);
    issue(hi ? 3'd3 : 3'd4, 32'h0, 32'h0, 32'h0, 1'b0);
    chk({tag, " R5 zero"}, {31'h0, flag_zero}, {31'h0, m_acc == 42'h0});
    chk({tag, " R6 neg"}, {31'h0, flag_neg}, {31'h0, m_acc[41]});
    chk({tag, " R6 ovf"}, {31'h0, flag_ovf}, 32'h0);
  endtask

  task automatic mac(input logic [31:0] pa, input logic [31:0] pb, input logic same,
                     input string tag);
    logic [15:0] a, b;
    logic signed [31:0] p;
    a = mem[pa[5:1]];
    b = same ? mem[pa[5:1] + 5'd1] : mem[pb[5:1]];
    p = $signed(a) * $signed(b);
    m_acc = m_acc + {{10{p[31]}}, p};
    push(tag, 32'h0, same ? pa + 4 : pa + 2, same ? pa + 4 : pb + 2);
    issue(3'd5, 32'h0, pa, pb, same);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    cmd_valid = 0; cmd_op = 0; cmd_wdata = 0; cmd_ptr_a = 0; cmd_ptr_b = 0; cmd_same_ptr = 0;
    m_acc = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", {31'h0, cmd_ready}, 32'h1);
    chk("R10 flags", {28'h0, flag_zero, flag_neg, flag_ovf, flag_carry}, 32'h0);
    chk("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    store(1'b1, "R10 hi after reset");
    store(1'b0, "R10 lo after reset");

    // R3 / R4 load and read back
    load(1'b0, 32'ha5a5a5a5);
    store(1'b0, "R4 lo readback");
    load(1'b1, 32'ha5a5a5a5);
    store(1'b1, "R3 hi truncated");
    // R1 clear keeps flags
    clr_cmd("R1 clear");
    chk("R1 flags kept", {30'h0, flag_zero, flag_neg}, 32'h0);
    store(1'b1, "R1 hi zero");
    store(1'b0, "R1 lo zero");

    // R4 sign extension of upper part, R6 negative
    load(1'b1, 32'h0000_0200);
    store(1'b1, "R4 hi sign ext");

    // R2 basic products
    clr_cmd("R1 clear");
    mem[0] = 16'd2; mem[1] = 16'd2;
    mac(32'd0, 32'd2, 1'b0, "R7 2x2");
    store(1'b0, "R2 2x2 lo");
    store(1'b1, "R5 2x2 hi zero not whole");

    clr_cmd("R1 clear");
    mem[0] = 16'd2; mem[1] = 16'd4;
    mac(32'd0, 32'd0, 1'b1, "R7 same ptr");
    store(1'b0, "R7 same lo");

    clr_cmd("R1 clear");
    mem[0] = 16'd0; mem[1] = 16'd0;
    mac(32'd0, 32'd2, 1'b0, "R7 0x0");
    store(1'b0, "R5 0x0 lo");

    clr_cmd("R1 clear");
    mem[0] = 16'hfffe; mem[1] = 16'd2;
    mac(32'd0, 32'd2, 1'b0, "R7 neg");
    store(1'b0, "R2 neg lo");
    store(1'b1, "R4 neg hi");

    // R8 carry into upper part
    clr_cmd("R1 clear");
    for (int i = 2; i < 18; i++) mem[i] = 16'h7fff;
    for (int k = 0; k < 8; k++) mac(32'd4 + 32'(k * 4), 32'd0, 1'b1, "R7 array");
    store(1'b0, "R8 lo");
    store(1'b1, "R8 hi");
    chk("R8 model lo", m_acc[31:0], 32'hfff80008);
    chk("R8 model hi", {22'h0, m_acc[41:32]}, 32'h1);

    // R2 wrap modulo 2^42
    load(1'b1, 32'h3ff);
    load(1'b0, 32'hffffffff);
    mem[0] = 16'd1; mem[1] = 16'd1;
    mac(32'd0, 32'd2, 1'b0, "R7 wrap");
    store(1'b0, "R2 wrap lo");
    store(1'b1, "R2 wrap hi");

    // R11 unused codes
    load(1'b0, 32'h0000_1234);
    issue(3'd6, 32'hffffffff, 32'h0, 32'h0, 1'b0);
    issue(3'd7, 32'hffffffff, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    store(1'b0, "R11 state kept");

    // R9 timing and busy ignore
    mem[0] = 16'd3; mem[1] = 16'd5;
    m_acc = m_acc + 42'd15;
    push("R9 busy acc", 32'h0, 32'd2, 32'd4);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd5; cmd_ptr_a = 32'd0; cmd_ptr_b = 32'd2; cmd_same_ptr = 0;
    @(negedge clk);
    chk("R9 mem_req", {31'h0, mem_req}, 32'h1);
    chk("R9 mem_addr", mem_addr, 32'd0);
    chk("R9 ready low", {31'h0, cmd_ready}, 32'h0);
    cmd_op = 3'd0;
    @(negedge clk);
    chk("R9 second addr", mem_addr, 32'd2);
    @(negedge clk);
    cmd_valid = 0;
    chk("R9 no early rsp", {31'h0, rsp_valid}, 32'h0);
    @(negedge clk);
    chk("R9 rsp due", {31'h0, rsp_valid}, 32'h1);
    store(1'b0, "R9 clear ignored");

    repeat (3) @(negedge clk);
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R9: actual %0d pending responses expected 0", q_data.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule